// File: doc/BRIEF.md
# RGB Channel Order and Bus Packer

This block sits at the end of a parallel video pipeline. Each cycle it may receive one 24-bit pixel, eight bits each of red, green and blue, together with a valid strobe. A 2-bit order code first selects which source channel becomes the first, second and third channel. A 3-bit format code then selects how those three channels are truncated and laid out on a 24-bit parallel output bus. The supported layouts are 16-bit 5-6-5 (fully packed, lane-aligned, or lane-aligned shifted up by one bit), 18-bit 6-6-6 (fully packed or lane-aligned) and 24-bit 8-8-8. One code forces the bus to zero.

The order and format codes are static configuration. They are sampled together with each valid pixel. The output is a register stage, so the packed word and its valid flag appear one clock after the input.

Top module: `rgb_bus_packer`

## Requirements
- R1: While rst_ni is low, and after its release until the first valid pixel, bus_o is 0 and valid_o is 0.
- R2: The order code (order_i) assigns source channels to the first/second/third channel: 0 gives R,G,B; 1 gives B,G,R; 2 gives G,R,B; 3 gives B,R,G. Red is pixel_i[23:16], green is pixel_i[15:8] and blue is pixel_i[7:0].
- R3: Format codes 0 and 7 drive all 24 bits of bus_o to zero.
- R4: Format 1 places the first channel's 5 bits at bus_o[15:11], the second channel's 6 bits at [10:5] and the third channel's 5 bits at [4:0]. Bits [23:16] are zero.
- R5: Format 2 places the first channel's 5 bits at bus_o[20:16], the second channel's 6 bits at [13:8] and the third channel's 5 bits at [4:0]. All other bits are zero.
- R6: Format 3 places the first channel's 5 bits at bus_o[21:17], the second channel's 6 bits at [13:8] and the third channel's 5 bits at [5:1]. All other bits are zero.
- R7: Format 4 packs three 6-bit channels into bus_o[17:0], first channel highest. Bits [23:18] are zero.
- R8: Format 5 places the 6-bit first, second and third channels at bus_o[21:16], [13:8] and [5:0]. Bits 23:22, 15:14 and 7:6 are zero.
- R9: Format 6 outputs the first channel at bus_o[23:16], the second at [15:8] and the third at [7:0], each with all 8 bits.
- R10: Truncation to 5 or 6 bits keeps the channel's most significant bits and drops the low bits.
- R11: bus_o and valid_o reflect an accepted pixel exactly one clock after valid_i was high. valid_o is low one clock after valid_i was low.
- R12: When valid_i is low, bus_o holds its previous value, whatever pixel_i, order_i and format_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Pixel valid strobe |
| pixel_i | input | 24 | Input pixel, R[23:16] G[15:8] B[7:0] |
| order_i | input | 2 | Channel order code |
| format_i | input | 3 | Output layout code |
| valid_o | output | 1 | Registered valid flag |
| bus_o | output | 24 | Packed output bus |

## Verification
The bench builds the block with its default channel width of 8. At that width the three lanes are bytes, and every bit position in the requirements falls on a real bus bit. Every format code is exercised, including the reserved one. Pixels with distinct channel values make each lane's source channel visible under all four orders. Pixels with set low bits only, or set high bits only, expose truncation faults. Holding and latency are checked by changing the inputs while valid_i is low and by sampling before and after the output edge.

// File: rtl/pkp_pkg.sv
package pkp_pkg;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    FMT_ZERO   = 3'd0,
    FMT_565P   = 3'd1,
    FMT_565L   = 3'd2,
    FMT_565LS  = 3'd3,
    FMT_666P   = 3'd4,
    FMT_666L   = 3'd5,
    FMT_888    = 3'd6,
    FMT_RSVD   = 3'd7
  } format_e;

  localparam int unsigned NUM_CH = 3;

endpackage

// File: rtl/pkp_swap.sv
module pkp_swap
  import pkp_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0] red_i,
  input  logic [CH_W-1:0] grn_i,
  input  logic [CH_W-1:0] blu_i,
  input  logic [1:0]      order_i,
  output logic [CH_W-1:0] ch0_o,
  output logic [CH_W-1:0] ch1_o,
  output logic [CH_W-1:0] ch2_o
);

  order_e ord;
  assign ord = order_e'(order_i);

  always_comb begin
    unique case (ord)
      ORD_BGR: begin ch0_o = blu_i; ch1_o = grn_i; ch2_o = red_i; end
      ORD_GRB: begin ch0_o = grn_i; ch1_o = red_i; ch2_o = blu_i; end
      ORD_BRG: begin ch0_o = blu_i; ch1_o = red_i; ch2_o = grn_i; end
      default: begin ch0_o = red_i; ch1_o = grn_i; ch2_o = blu_i; end
    endcase
  end

endmodule

// File: rtl/pkp_format.sv
module pkp_format
  import pkp_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0]          ch0_i,
  input  logic [CH_W-1:0]          ch1_i,
  input  logic [CH_W-1:0]          ch2_i,
  input  logic [2:0]               format_i,
  output logic [NUM_CH*CH_W-1:0]   word_o
);

  localparam int unsigned BUS_W = NUM_CH * CH_W;
  localparam int unsigned W5    = 5;
  localparam int unsigned W6    = 6;
  localparam int unsigned LANE1 = CH_W;
  localparam int unsigned LANE2 = 2 * CH_W;

  // MSB-kept truncations, one set per channel
  logic [W5-1:0] t5 [NUM_CH];
  logic [W6-1:0] t6 [NUM_CH];
  logic [CH_W-1:0] chs [NUM_CH];

  assign chs[0] = ch0_i;
  assign chs[1] = ch1_i;
  assign chs[2] = ch2_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_trunc
    assign t5[g] = chs[g][CH_W-1 -: W5];
    assign t6[g] = chs[g][CH_W-1 -: W6];
  end

  format_e fmt;
  assign fmt = format_e'(format_i);

  always_comb begin
    word_o = '0;
    unique case (fmt)
      FMT_565P: begin
        word_o[2*W5+W6-1:0] = {t5[0], t6[1], t5[2]};
      end
      FMT_565L: begin
        word_o[LANE2 +: W5] = t5[0];
        word_o[LANE1 +: W6] = t6[1];
        word_o[0     +: W5] = t5[2];
      end
      FMT_565LS: begin
        word_o[LANE2+1 +: W5] = t5[0];
        word_o[LANE1   +: W6] = t6[1];
        word_o[1       +: W5] = t5[2];
      end
      FMT_666P: begin
        word_o[3*W6-1:0] = {t6[0], t6[1], t6[2]};
      end
      FMT_666L: begin
        word_o[LANE2 +: W6] = t6[0];
        word_o[LANE1 +: W6] = t6[1];
        word_o[0     +: W6] = t6[2];
      end
      FMT_888: begin
        word_o = {ch0_i, ch1_i, ch2_i};
      end
      default: word_o = '0;
    endcase
  end

  initial begin
    assert (CH_W >= W6 + 1) else $error("CH_W too narrow for lane layouts");
  end

endmodule

// File: rtl/pkp_out_reg.sv
module pkp_out_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] word_i,
  output logic         valid_o,
  output logic [W-1:0] word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) word_o <= word_i;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(word_o)); // R12

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11

  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R11

endmodule

// File: rtl/rgb_bus_packer.sv
module rgb_bus_packer
  import pkp_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [NUM_CH*CH_W-1:0] pixel_i,
  input  logic [1:0]             order_i,
  input  logic [2:0]             format_i,
  output logic                   valid_o,
  output logic [NUM_CH*CH_W-1:0] bus_o
);

  localparam int unsigned BUS_W = NUM_CH * CH_W;

  logic [CH_W-1:0]  ch0, ch1, ch2;
  logic [BUS_W-1:0] packed_word;

  pkp_swap #(.CH_W(CH_W)) u_swap (
    .red_i   (pixel_i[2*CH_W +: CH_W]),
    .grn_i   (pixel_i[CH_W   +: CH_W]),
    .blu_i   (pixel_i[0      +: CH_W]),
    .order_i (order_i),
    .ch0_o   (ch0),
    .ch1_o   (ch1),
    .ch2_o   (ch2)
  );

  pkp_format #(.CH_W(CH_W)) u_fmt (
    .ch0_i    (ch0),
    .ch1_i    (ch1),
    .ch2_i    (ch2),
    .format_i (format_i),
    .word_o   (packed_word)
  );

  pkp_out_reg #(.W(BUS_W)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .word_i  (packed_word),
    .valid_o (valid_o),
    .word_o  (bus_o)
  );

  AST_ZERO_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (format_i == 3'd0 || format_i == 3'd7) |=> bus_o == '0); // R3

  AST_565P_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && format_i == 3'd1 |=> bus_o[BUS_W-1:16] == '0); // R4

  AST_666L_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && format_i == 3'd5 |=>
      bus_o[2*CH_W+6 +: 2] == 2'b00 && bus_o[CH_W+6 +: 2] == 2'b00 && bus_o[6 +: 2] == 2'b00); // R8

  AST_888_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && format_i == 3'd6 && order_i == 2'd0 |=> bus_o == $past(pixel_i)); // R9

  AST_666P_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && format_i == 3'd4 |=> bus_o[BUS_W-1:18] == '0); // R7

endmodule

// File: tb/sim_rgb_bus_packer.sv
`timescale 1ns/1ps
module sim_rgb_bus_packer;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] pixel_i = '0;
  logic [1:0]  order_i = '0;
  logic [2:0]  format_i = '0;
  logic        valid_o;
  logic [23:0] bus_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rgb_bus_packer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pixel_i(pixel_i),
    .order_i(order_i), .format_i(format_i), .valid_o(valid_o), .bus_o(bus_o)
  );

  function automatic logic [23:0] model(input logic [23:0] p, input logic [1:0] o, input logic [2:0] f);
    logic [7:0] r, g, b, a, m, c;
    logic [23:0] w;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    case (o)
      2'd0: begin a = r; m = g; c = b; end
      2'd1: begin a = b; m = g; c = r; end
      2'd2: begin a = g; m = r; c = b; end
      default: begin a = b; m = r; c = g; end
    endcase
    w = '0;
    case (f)
      3'd1: w = {8'h00, a[7:3], m[7:2], c[7:3]};
      3'd2: w = {3'b000, a[7:3], 2'b00, m[7:2], 3'b000, c[7:3]};
      3'd3: w = {2'b00, a[7:3], 3'b000, m[7:2], 2'b00, c[7:3], 1'b0};
      3'd4: w = {6'h00, a[7:2], m[7:2], c[7:2]};
      3'd5: w = {2'b00, a[7:2], 2'b00, m[7:2], 2'b00, c[7:2]};
      3'd6: w = {a, m, c};
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] p, input logic [1:0] o, input logic [2:0] f, input string req);
    @(negedge clk_i);
    valid_i = 1'b1; pixel_i = p; order_i = o; format_i = f;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, bus_o, model(p, o, f));
    check({req, " valid"}, {23'd0, valid_o}, 24'd1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 bus in reset", bus_o, 24'h0);
    check("R1 valid in reset", {23'd0, valid_o}, 24'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 bus after reset", bus_o, 24'h0);
  endtask

  task automatic t_orders();
    for (int o = 0; o < 4; o++) push(24'h11_22_33, 2'(o), 3'd6, "R2/R9 order");
    push(24'hA5_3C_E7, 2'd0, 3'd6, "R9 passthrough");
    check("R9 literal", bus_o, 24'hA5_3C_E7);
    push(24'hA5_3C_E7, 2'd3, 3'd6, "R2 brg");
    check("R2 literal", bus_o, 24'hE7_A5_3C);
  endtask

  task automatic t_formats();
    logic [23:0] pats [3] = '{24'hFF_FF_FF, 24'hA5_3C_E7, 24'h5A_C3_7E};
    foreach (pats[i])
      for (int f = 0; f < 8; f++)
        for (int o = 0; o < 4; o++) push(pats[i], 2'(o), 3'(f), "R3..R8 format");
    push(24'hFF_FF_FF, 2'd0, 3'd0, "R3 zero");
    check("R3 literal", bus_o, 24'h0);
    push(24'hFF_FF_FF, 2'd0, 3'd7, "R3 reserved");
    push(24'hFF_FF_FF, 2'd0, 3'd1, "R4");
    check("R4 literal", bus_o, 24'h00_FFFF);
    push(24'hFF_FF_FF, 2'd0, 3'd2, "R5");
    check("R5 literal", bus_o, 24'h1F_3F_1F);
    push(24'hFF_FF_FF, 2'd0, 3'd3, "R6");
    check("R6 literal", bus_o, 24'h3E_3F_3E);
    push(24'hFF_FF_FF, 2'd0, 3'd4, "R7");
    check("R7 literal", bus_o, 24'h03_FFFF);
    push(24'hFF_FF_FF, 2'd0, 3'd5, "R8");
    check("R8 literal", bus_o, 24'h3F_3F_3F);
  endtask

  task automatic t_trunc();
    push(24'h07_03_07, 2'd0, 3'd1, "R10 low bits dropped");
    check("R10 565 low", bus_o, 24'h0);
    push(24'h03_03_03, 2'd0, 3'd4, "R10 666 low");
    check("R10 666 literal", bus_o, 24'h0);
    push(24'hF8_FC_F8, 2'd0, 3'd1, "R10 msbs kept");
    check("R10 565 high", bus_o, 24'h00_FFFF);
  endtask

  task automatic t_latency_hold();
    push(24'h12_34_56, 2'd0, 3'd6, "R11 base");
    @(negedge clk_i);
    check("R11 valid drops", {23'd0, valid_o}, 24'd0);
    valid_i = 1'b1; pixel_i = 24'hAB_CD_EF; order_i = 2'd0; format_i = 3'd6;
    #1;
    check("R11 not before edge", bus_o, 24'h12_34_56);
    @(negedge clk_i);
    check("R11 after edge", bus_o, 24'hAB_CD_EF);
    valid_i = 1'b0; pixel_i = 24'h00_00_00; format_i = 3'd0; order_i = 2'd1;
    @(negedge clk_i);
    pixel_i = 24'h99_88_77; format_i = 3'd2;
    @(negedge clk_i);
    check("R12 hold", bus_o, 24'hAB_CD_EF);
    check("R12 valid low", {23'd0, valid_o}, 24'd0);
  endtask

  initial begin
    t_reset();
    t_orders();
    t_formats();
    t_trunc();
    t_latency_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule